// File: doc/BRIEF.md
# SPI Master Control Register

This block is the host-visible control word of an SPI master. The host loads the word with a write strobe. The stored value is always present on a parallel read bus and on the block's dedicated outputs. Other logic can therefore use every field at any time, whether or not the host is currently addressing the block.

The block contains three pieces of logic:

- **Rate-tick generator.** A free-running divider, fed by the system clock, offers four power-of-two taps. A two-bit rate field picks one of them, and the block emits a single-cycle tick at the chosen rate. The transfer engine uses this tick to pace its serial clock.
- **Chip-select decoder.** It turns a two-bit device number and an enable bit into four active-low chip selects. Reset drives every select high.
- **Completion flag.** The transfer engine sets this flag with a one-cycle pulse. The host clears it by writing a zero to its bit. An interrupt request follows the flag whenever the interrupt-enable bit is set.

Top module: `spi_ctrl_reg`

## Requirements
- R1: While reset is asserted, the read bus is 0x00, all four chip selects are high and the interrupt request is low.
- R2: A write stores bits 7, 5, 4, 3:2 and 1:0 of the write data. The read bus shows them one cycle after the write edge, and bit 6 always reads as 0.
- R3: The rate field in bits 1:0 sets the tick period to 2, 4, 8 or 16 system clocks for codes 0, 1, 2 and 3. Each tick lasts one cycle.
- R4: The divider is never cleared. After a rate change, the first tick arrives within one new period, and later ticks keep the new period.
- R5: When the enable bit (bit 4) is 1, exactly one chip select is low: the one whose index equals the select field in bits 3:2, where 0 is cs_n[0] and 3 is cs_n[3].
- R6: When the enable bit is 0, all four chip selects are high, whatever the select field holds.
- R7: A one-cycle pulse on xfer_done sets bit 7 on the next edge without a host write. The other fields are left unchanged.
- R8: A host write with bit 7 equal to 0 clears the flag, and a host write with bit 7 equal to 1 sets it.
- R9: When xfer_done and a write that clears bit 7 come in the same cycle, the flag ends up set. The write's other fields still take effect.
- R10: irq is high exactly when bit 5 (interrupt enable) and bit 7 (completion flag) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Host write data |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| rd_data | output | 8 | Stored control word, bit 6 forced to 0 |
| rate_tick | output | 1 | One-cycle tick at the selected rate |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
Corruption in the stored word reaches the outputs in the same cycle as the faulty edge:

- A flipped select or enable bit shows at once as a wrong or extra low line on cs_n.
- A lost completion flag shows as a missing irq on the cycle after xfer_done.

A fault in the divider or in the tap selection is slower to see. It appears as a wrong gap between consecutive rate ticks, which can take up to sixteen cycles to show. The bench therefore measures at least one full period for every rate code. It also times the first tick after a rate change.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int WORD_W    = 8;
  localparam int RATE_LO   = 0;
  localparam int RATE_W    = 2;
  localparam int DEVSEL_LO = 2;
  localparam int DEVSEL_W  = 2;
  localparam int DEV_EN_B  = 4;
  localparam int IRQ_EN_B  = 5;
  localparam int SPARE_B   = 6;
  localparam int FLAG_B    = 7;

  typedef struct packed {
    logic                flag;
    logic                irq_en;
    logic                dev_en;
    logic [DEVSEL_W-1:0] dev_sel;
    logic [RATE_W-1:0]   rate;
  } ctrl_word_t;

  function automatic int tick_period(input int code);
    return 2 << code;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input ctrl_word_t w);
    logic [WORD_W-1:0] v;
    v = '0;
    v[FLAG_B]   = w.flag;
    v[IRQ_EN_B] = w.irq_en;
    v[DEV_EN_B] = w.dev_en;
    v[DEVSEL_LO +: DEVSEL_W] = w.dev_sel;
    v[RATE_LO +: RATE_W]     = w.rate;
    v[SPARE_B]  = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
  parameter int NUM_TAPS = 4,
  localparam int SEL_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tick
);
  // Free-running: never cleared, so a rate change never restarts it.
  logic [NUM_TAPS-1:0] div_cnt = '0;
  logic [NUM_TAPS-1:0] tap_hit;

  always_ff @(posedge clk) div_cnt <= div_cnt + 1'b1;

  // Tap k fires once every 2^(k+1) clocks, when the low k+1 bits are all ones.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap_hit[k] = &div_cnt[k:0];
  end

  assign tick = tap_hit[tap_sel];
endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              enable,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(enable && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/done_flag.sv
module done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag
);
  // A completion event takes priority over a host write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (wr_en)   flag <= wr_bit;
  end
endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_ctrl_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int NUM_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              xfer_done,
  output logic [WORD_W-1:0] rd_data,
  output logic              rate_tick,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  ctrl_word_t word_q;
  logic       flag_q;
  logic       flag_set_evt;

  assign flag_set_evt = xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q.irq_en  <= 1'b0;
      word_q.dev_en  <= 1'b0;
      word_q.dev_sel <= '0;
      word_q.rate    <= '0;
    end else if (wr_en) begin
      word_q.irq_en  <= wr_data[IRQ_EN_B];
      word_q.dev_en  <= wr_data[DEV_EN_B];
      word_q.dev_sel <= wr_data[DEVSEL_LO +: DEVSEL_W];
      word_q.rate    <= wr_data[RATE_LO +: RATE_W];
    end
  end

  always_comb word_q.flag = flag_q;

  done_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (flag_set_evt),
    .wr_en   (wr_en),
    .wr_bit  (wr_data[FLAG_B]),
    .flag    (flag_q)
  );

  rate_tick_gen #(.NUM_TAPS(NUM_TAPS)) u_rate (
    .clk     (clk),
    .tap_sel (word_q.rate),
    .tick    (rate_tick)
  );

  cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .enable (word_q.dev_en),
    .sel    (word_q.dev_sel),
    .cs_n   (cs_n)
  );

  assign rd_data = pack_word(word_q);
  assign irq     = word_q.irq_en && flag_q;
endmodule

// File: rtl/spi_ctrl_reg_chk.sv
module spi_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       xfer_done,
  input logic [7:0] rd_data,
  input logic       rate_tick,
  input logic [3:0] cs_n,
  input logic       irq
);
  logic [5:0] gap;
  logic       clean;
  logic [1:0] prev_rate;

  // gap counts cycles since the last tick; clean means the rate has not
  // changed since that tick, so the next gap must equal the full period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; clean <= 1'b0; prev_rate <= '0;
    end else begin
      prev_rate <= rd_data[1:0];
      if (rate_tick) begin
        gap <= 6'd1; clean <= 1'b1;
      end else begin
        if (gap != 6'h3f) gap <= gap + 1'b1;
        if (prev_rate != rd_data[1:0]) clean <= 1'b0;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (rd_data == 8'h00 && cs_n == 4'hf && !irq));
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == 1'b0);
  a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_tick && clean && prev_rate == rd_data[1:0]) |-> (gap == (6'd2 << rd_data[1:0])));
  a_r5_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> ($countones(~cs_n) == 1 && !cs_n[rd_data[3:2]]));
  a_r6_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> cs_n == 4'hf);
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> rd_data[7]);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7] && !xfer_done) |=> !rd_data[7]);
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[5] && rd_data[7]));
endmodule

bind spi_ctrl_reg spi_ctrl_reg_chk u_chk (.*);

// File: tb/sim_spi_ctrl_reg.sv
`timescale 1ns/1ps
module sim_spi_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       xfer_done = 1'b0;
  logic [7:0] rd_data;
  logic       rate_tick;
  logic [3:0] cs_n;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  spi_ctrl_reg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xfer_done(xfer_done), .rd_data(rd_data), .rate_tick(rate_tick),
    .cs_n(cs_n), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, sample at the next falling edge.
  task automatic host_write(input logic [7:0] v, input logic done);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; xfer_done = done;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  function automatic logic [3:0] exp_cs(input logic en, input logic [1:0] s);
    logic [3:0] v;
    v = 4'hf;
    if (en) v[s] = 1'b0;
    return v;
  endfunction

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 cs_n", cs_n, 4'hf);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_readback();
    host_write(8'h7f, 1'b0);
    chk("R2 bit6 masked", rd_data, 8'h3f);
    host_write(8'h00, 1'b0);
    chk("R2 cleared", rd_data, 8'h00);
  endtask

  task automatic t_rate(input int code);
    int first, per, wait_n;
    host_write(8'(code), 1'b0);
    // R4: the first tick after a change comes within one new period
    first = 0;
    while (!rate_tick && first < 40) begin @(negedge clk); first++; end
    checks++;
    if (first >= (2 << code)) begin
      errors++;
      $display("FAIL R4: first tick after %0d cycles, expected < %0d", first, 2 << code);
    end
    for (int rep = 0; rep < 2; rep++) begin
      per = 0;
      @(negedge clk); per++;
      wait_n = 0;
      while (!rate_tick && wait_n < 40) begin @(negedge clk); per++; wait_n++; end
      chk("R3 period", per, 2 << code);
    end
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      host_write(8'h10 | 8'(s << 2), 1'b0);
      chk("R5 one low", cs_n, exp_cs(1'b1, 2'(s)));
    end
    host_write(8'h0c, 1'b0);
    chk("R6 disabled", cs_n, 4'hf);
  endtask

  task automatic t_flag();
    host_write(8'h3a, 1'b0);
    chk("R10 irq off, no flag", irq, 0);
    pulse_done();
    chk("R7 flag set, fields kept", rd_data, 8'hba);
    chk("R10 irq on", irq, 1);
    host_write(8'h3a, 1'b0);
    chk("R8 cleared by write 0", rd_data[7], 0);
    chk("R10 irq off after clear", irq, 0);
    host_write(8'h80, 1'b0);
    chk("R8 set by write 1", rd_data, 8'h80);
    chk("R10 irq off, disabled", irq, 0);
    host_write(8'h25, 1'b1);
    chk("R9 done wins over clear", rd_data, 8'ha5);
    chk("R10 irq with flag", irq, 1);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_readback();
    for (int c = 0; c < 4; c++) t_rate(c);
    t_rate(0);
    t_rate(3);
    t_select();
    t_flag();
    done_run = 1'b1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule